// File: doc/BRIEF.md
# Alarm Page Commit Sequencer

This block stands between a byte-wide register write path and the nonvolatile copy of a 16-byte alarm page. A write burst opens with a start event that carries the first address. Each byte strobe then stores one byte in a volatile shadow page and steps the address by one. The address wraps from the top of the page back to zero. A stop event closes the burst. At that point the block decides from the address of the last accepted byte whether the shadow page must be copied into the nonvolatile image.

The page is treated as two 8-byte halves. A commit starts only when the burst's final byte sits at offset 0 to 4 inside either half. A burst that ends anywhere else leaves its bytes in the shadow page without storing them. To store those upper bytes, software writes on past them into the low bytes of the next half, using the wrap where needed. A commit holds a busy flag for a fixed number of cycles and copies the page at its end.

Writes are accepted only when a two-stage enable is fully armed. Arm sets the first stage, and confirm sets the second stage only if the first is already set. Finishing a commit drops both stages. A registered read port returns shadow bytes, and using it in the middle of a burst does not disturb the burst.

Top module: `alarm_page_commit`

## Requirements
- R1: The page holds 16 bytes. Within a burst the write address increments by one after each accepted byte and wraps from 0xF to 0x0.
- R2: At a stop event, a commit starts if and only if at least one byte was accepted in the burst and the last accepted byte's address is in 0x0–0x4 or 0x8–0xC.
- R3: A burst whose last byte is at 0x5, 0x6, 0x7, 0xD, 0xE or 0xF starts no commit. The written bytes stay visible in the shadow page and the nonvolatile image is unchanged. A later burst that continues into a window address commits them.
- R4: A 16-byte burst starting at 0x1 and ending at 0x0, or starting at 0x9 and ending at 0x8, commits all 16 bytes.
- R5: `commit_busy` rises on the clock edge that samples the committing stop event and stays high for exactly COMMIT_CYCLES cycles. `commit_req` is high only during the first of those cycles.
- R6: The nonvolatile image changes only on the last busy cycle. At that point it takes a copy of the whole shadow page.
- R7: The end of a commit clears both enable stages.
- R8: Confirm sets stage 2 only when stage 1 is already set. A burst started without both stages set is discarded: the shadow page does not change.
- R9: While busy, start events, byte strobes and stop events are ignored. The shadow page does not change and no new commit starts.
- R10: A read (`rd_en`) returns the addressed shadow byte one cycle later. Reads issued between the bytes of a burst do not abort it or shift its address.
- R11: A stop event with no accepted byte in the burst starts no commit and leaves the enable stages set.
- R12: After reset the shadow page, nonvolatile image, enable stages, busy and request outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Opens a burst at `start_addr` |
| start_addr | input | ADDR_W | First byte address of the burst |
| byte_wr | input | 1 | Byte strobe within an open burst |
| byte_data | input | DATA_W | Byte to store |
| xfer_stop | input | 1 | Closes the burst; may start a commit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| wen_arm | input | 1 | Sets enable stage 1 |
| wen_confirm | input | 1 | Sets enable stage 2 if stage 1 is set |
| rd_data | output | DATA_W | Registered read result |
| shadow_flat | output | DATA_W*2**ADDR_W | Shadow page, byte i at bits [8i+7:8i] |
| nv_flat | output | DATA_W*2**ADDR_W | Nonvolatile image, same layout |
| commit_req | output | 1 | First cycle of a commit |
| commit_busy | output | 1 | Commit in progress |
| wen_stage1 | output | 1 | Enable stage 1 |
| wen_stage2 | output | 1 | Enable stage 2 |

## Verification
The stop decision is tried with a single-byte burst at each of the 16 addresses. This separates window ends from non-window ends one address at a time. Bursts that cross the 0xF to 0x0 wrap, and full 16-byte bursts from 0x1 and 0x9, show whether the pointer wraps and whether the whole page is copied. Bursts ending at 0x6, 0x7 and 0xF, followed by a burst from 0x6 that overlaps into 0x8, separate "held in the shadow page" from "stored". Writes during busy, writes with a partial enable, an empty burst and reads placed between bytes show that the ignored inputs leave the shadow page, the pointer and the enable stages untouched.

// File: rtl/apc_pkg.sv
package apc_pkg;

  // True when an address closes a burst inside a commit window:
  // the offset within its sub-block lies below the window span.
  function automatic logic in_window(input int unsigned addr,
                                     input int unsigned sub_bytes,
                                     input int unsigned span);
    return (addr % sub_bytes) < span;
  endfunction

  // Next burst address, wrapping inside the page.
  function automatic int unsigned wrap_inc(input int unsigned addr,
                                           input int unsigned page_bytes);
    return (addr + 1) % page_bytes;
  endfunction

endpackage

// File: rtl/apc_wen_latch.sv
module apc_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic confirm,
  input  logic clear,
  output logic stage1,
  output logic stage2
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else if (clear) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      if (arm)                stage1 <= 1'b1;
      if (confirm && stage1)  stage2 <= 1'b1;
    end
  end

endmodule

// File: rtl/apc_burst_tracker.sv
module apc_burst_tracker #(
  parameter int ADDR_W    = 4,
  parameter int SUB_BYTES = 8,
  parameter int WIN_SPAN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_wr,
  input  logic              xfer_stop,
  input  logic              allow,
  output logic              wr_ok,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              commit_fire
);

  localparam int PAGE_BYTES = 1 << ADDR_W;

  logic              active_q;
  logic              wrote_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] last_q;
  logic              last_in_win;

  assign last_in_win = apc_pkg::in_window(32'(last_q), SUB_BYTES, WIN_SPAN);
  assign wr_ok       = active_q && byte_wr && allow;
  assign wr_addr     = ptr_q;
  assign commit_fire = active_q && xfer_stop && allow && wrote_q && last_in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wrote_q  <= 1'b0;
      ptr_q    <= '0;
      last_q   <= '0;
    end else if (xfer_start) begin
      active_q <= allow;
      wrote_q  <= 1'b0;
      ptr_q    <= start_addr;
    end else if (xfer_stop) begin
      active_q <= 1'b0;
      wrote_q  <= 1'b0;
    end else if (wr_ok) begin
      ptr_q   <= ADDR_W'(apc_pkg::wrap_inc(32'(ptr_q), PAGE_BYTES));
      last_q  <= ptr_q;
      wrote_q <= 1'b1;
    end
  end

endmodule

// File: rtl/apc_commit_timer.sv
module apc_commit_timer #(
  parameter int COMMIT_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy,
  output logic req,
  output logic done
);

  localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(COMMIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign req  = busy && (cnt_q == LOAD);
  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (fire) begin
        busy  <= 1'b1;
        cnt_q <= LOAD;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/apc_shadow_page.sv
module apc_shadow_page #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_ok,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                copy_now,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   rd_addr,
  output logic [DATA_W-1:0]                   rd_data,
  output logic [DATA_W*(1<<ADDR_W)-1:0]       shadow_flat,
  output logic [DATA_W*(1<<ADDR_W)-1:0]       nv_flat
);

  localparam int PAGE_BYTES = 1 << ADDR_W;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] nv_q;
    logic              hit;

    assign hit = wr_ok && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
        nv_q <= '0;
      end else begin
        if (hit)      sh_q <= wr_data;
        if (copy_now) nv_q <= sh_q;
      end
    end

    assign shadow_flat[g*DATA_W +: DATA_W] = sh_q;
    assign nv_flat[g*DATA_W +: DATA_W]     = nv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= shadow_flat[rd_addr*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/alarm_page_commit.sv
module alarm_page_commit #(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter int SUB_BYTES     = 8,
  parameter int WIN_SPAN      = 5,
  parameter int COMMIT_CYCLES = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          xfer_start,
  input  logic [ADDR_W-1:0]             start_addr,
  input  logic                          byte_wr,
  input  logic [DATA_W-1:0]             byte_data,
  input  logic                          xfer_stop,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic                          wen_arm,
  input  logic                          wen_confirm,
  output logic [DATA_W-1:0]             rd_data,
  output logic [DATA_W*(1<<ADDR_W)-1:0] shadow_flat,
  output logic [DATA_W*(1<<ADDR_W)-1:0] nv_flat,
  output logic                          commit_req,
  output logic                          commit_busy,
  output logic                          wen_stage1,
  output logic                          wen_stage2
);

  // Named internal events, visible to the bound checker.
  logic              allow_wr;
  logic              wr_ok;
  logic [ADDR_W-1:0] wr_addr;
  logic              commit_fire;
  logic              commit_done;

  assign allow_wr = wen_stage1 && wen_stage2 && !commit_busy;

  apc_wen_latch u_wen (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (wen_arm),
    .confirm (wen_confirm),
    .clear   (commit_done),
    .stage1  (wen_stage1),
    .stage2  (wen_stage2)
  );

  apc_burst_tracker #(
    .ADDR_W    (ADDR_W),
    .SUB_BYTES (SUB_BYTES),
    .WIN_SPAN  (WIN_SPAN)
  ) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_start  (xfer_start),
    .start_addr  (start_addr),
    .byte_wr     (byte_wr),
    .xfer_stop   (xfer_stop),
    .allow       (allow_wr),
    .wr_ok       (wr_ok),
    .wr_addr     (wr_addr),
    .commit_fire (commit_fire)
  );

  apc_commit_timer #(
    .COMMIT_CYCLES (COMMIT_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (commit_fire),
    .busy  (commit_busy),
    .req   (commit_req),
    .done  (commit_done)
  );

  apc_shadow_page #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_page (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ok       (wr_ok),
    .wr_addr     (wr_addr),
    .wr_data     (byte_data),
    .copy_now    (commit_done),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .shadow_flat (shadow_flat),
    .nv_flat     (nv_flat)
  );

endmodule

// File: rtl/apc_checker.sv
module apc_checker #(
  parameter int PAGE_W        = 128,
  parameter int COMMIT_CYCLES = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_wr,
  input logic              xfer_stop,
  input logic              wr_ok,
  input logic              commit_busy,
  input logic              commit_req,
  input logic              commit_done,
  input logic              wen_stage1,
  input logic              wen_stage2,
  input logic [PAGE_W-1:0] shadow_flat,
  input logic [PAGE_W-1:0] nv_flat
);

  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_cnt <= 0;
    else if (commit_busy) busy_cnt <= busy_cnt + 1;
    else                  busy_cnt <= 0;
  end

  // R8
  stage2_needs_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen_stage2 |-> wen_stage1);

  // R8
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (wen_stage1 && wen_stage2));

  // R9
  busy_freezes_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_busy |=> $stable(shadow_flat));

  // R10
  no_strobe_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_wr |=> $stable(shadow_flat));

  // R6
  nv_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_done |=> $stable(nv_flat));

  // R6
  nv_takes_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (nv_flat == $past(shadow_flat)));

  // R7
  done_clears_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (!wen_stage1 && !wen_stage2));

  // R5
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(commit_busy) |-> (busy_cnt == COMMIT_CYCLES));

  // R5
  req_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> (commit_busy && !$past(commit_busy)));

  // R2
  start_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_busy) |-> $past(xfer_stop));

endmodule

bind alarm_page_commit apc_checker #(
  .PAGE_W        (DATA_W * (1 << ADDR_W)),
  .COMMIT_CYCLES (COMMIT_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_wr     (byte_wr),
  .xfer_stop   (xfer_stop),
  .wr_ok       (wr_ok),
  .commit_busy (commit_busy),
  .commit_req  (commit_req),
  .commit_done (commit_done),
  .wen_stage1  (wen_stage1),
  .wen_stage2  (wen_stage2),
  .shadow_flat (shadow_flat),
  .nv_flat     (nv_flat)
);

// File: tb/alarm_page_commit_tb.sv
`timescale 1ns/1ps
module alarm_page_commit_tb;

  localparam int NCYC = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         xfer_start = 0, byte_wr = 0, xfer_stop = 0, rd_en = 0;
  logic         wen_arm = 0, wen_confirm = 0;
  logic [3:0]   start_addr = 0, rd_addr = 0;
  logic [7:0]   byte_data = 0;
  logic [7:0]   rd_data;
  logic [127:0] shadow_flat, nv_flat;
  logic         commit_req, commit_busy, wen_stage1, wen_stage2;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] exp_sh [16];
  logic [7:0] exp_nv [16];
  int mptr;

  always #2.5 clk = ~clk;

  alarm_page_commit #(.COMMIT_CYCLES(NCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .start_addr(start_addr),
    .byte_wr(byte_wr), .byte_data(byte_data), .xfer_stop(xfer_stop),
    .rd_en(rd_en), .rd_addr(rd_addr), .wen_arm(wen_arm), .wen_confirm(wen_confirm),
    .rd_data(rd_data), .shadow_flat(shadow_flat), .nv_flat(nv_flat),
    .commit_req(commit_req), .commit_busy(commit_busy),
    .wen_stage1(wen_stage1), .wen_stage2(wen_stage2));

  function automatic bit window_end(input int a);
    return (a >= 0 && a <= 4) || (a >= 8 && a <= 12);
  endfunction

  function automatic logic [127:0] pack(input logic [7:0] b [16]);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = b[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_arm();
    @(negedge clk) wen_arm = 1;
    @(negedge clk) wen_arm = 0;
  endtask

  task automatic pulse_confirm();
    @(negedge clk) wen_confirm = 1;
    @(negedge clk) wen_confirm = 0;
  endtask

  task automatic enable_both();
    pulse_arm();
    pulse_confirm();
  endtask

  task automatic open_burst(input int a);
    @(negedge clk) begin xfer_start = 1; start_addr = 4'(a); end
    @(negedge clk) xfer_start = 0;
    mptr = a;
  endtask

  task automatic put_byte(input logic [7:0] d, input bit accept);
    @(negedge clk) begin byte_wr = 1; byte_data = d; end
    @(negedge clk) byte_wr = 0;
    if (accept) begin
      exp_sh[mptr] = d;
      mptr = (mptr + 1) % 16;
    end
  endtask

  // Pulse stop; on return the current negedge is the first one after it.
  task automatic close_burst();
    @(negedge clk) xfer_stop = 1;
    @(negedge clk) xfer_stop = 0;
  endtask

  // Closes a burst and checks the commit decision and its outcome.
  task automatic close_and_expect(input bit want, input string req);
    int n;
    int reqs;
    close_burst();
    check(commit_busy == want, req, 128'(commit_busy), 128'(want));
    if (want) begin
      n = 0;
      reqs = 0;
      while (commit_busy && n < 200) begin
        n++;
        if (commit_req) reqs++;
        @(negedge clk);
      end
      check(n == NCYC, "R5 busy length", 128'(n), 128'(NCYC));
      check(reqs == 1, "R5 single request", 128'(reqs), 128'd1);
      for (int i = 0; i < 16; i++) exp_nv[i] = exp_sh[i];
      check(nv_flat == pack(exp_nv), "R6 image copied", nv_flat, pack(exp_nv));
      check(!wen_stage1 && !wen_stage2, "R7 enables cleared",
            128'({wen_stage1, wen_stage2}), 128'd0);
    end else begin
      repeat (3) @(negedge clk);
      check(nv_flat == pack(exp_nv), {req, " image kept"}, nv_flat, pack(exp_nv));
    end
    check(shadow_flat == pack(exp_sh), {req, " shadow"}, shadow_flat, pack(exp_sh));
  endtask

  task automatic t_reset();
    check(shadow_flat == 0 && nv_flat == 0, "R12 page zero", shadow_flat, 0);
    check({commit_busy, commit_req, wen_stage1, wen_stage2, rd_data} == 0,
          "R12 flags zero", 128'({commit_busy, commit_req, wen_stage1, wen_stage2, rd_data}), 0);
  endtask

  task automatic t_enable_order();
    pulse_confirm();
    check(wen_stage2 == 0, "R8 confirm alone", 128'(wen_stage2), 0);
    pulse_arm();
    check(wen_stage1 == 1 && wen_stage2 == 0, "R8 arm only",
          128'({wen_stage1, wen_stage2}), 128'b10);
    open_burst(3);
    put_byte(8'h11, 0);
    close_and_expect(0, "R8 partial enable discards");
    pulse_confirm();
    check(wen_stage1 && wen_stage2, "R8 both set", 128'({wen_stage1, wen_stage2}), 128'b11);
  endtask

  task automatic t_wrap_commit();
    open_burst(14);
    put_byte(8'hA1, 1);
    put_byte(8'hA2, 1);
    put_byte(8'hA3, 1);
    check(exp_sh[0] == 8'hA3, "R1 wrap model", 128'(exp_sh[0]), 128'hA3);
    close_and_expect(1, "R1 R2 wrap to 0x0 commits");
  endtask

  task automatic t_upper_ends();
    enable_both();
    open_burst(5);
    put_byte(8'h55, 1);
    put_byte(8'h66, 1);
    close_and_expect(0, "R3 ends at 0x6");
    open_burst(7);
    put_byte(8'h77, 1);
    close_and_expect(0, "R3 ends at 0x7");
    open_burst(13);
    put_byte(8'hDD, 1);
    put_byte(8'hEE, 1);
    put_byte(8'hFF, 1);
    close_and_expect(0, "R3 ends at 0xF");
    open_burst(6);
    put_byte(8'h6A, 1);
    put_byte(8'h7A, 1);
    put_byte(8'h8A, 1);
    close_and_expect(1, "R3 overlap into 0x8 commits");
  endtask

  task automatic t_window_scan();
    for (int a = 0; a < 16; a++) begin
      enable_both();
      open_burst(a);
      put_byte(8'(8'h30 + a), 1);
      close_and_expect(window_end(a), $sformatf("R2 end at %0d", a));
    end
  endtask

  task automatic t_full_page(input int from);
    enable_both();
    open_burst(from);
    for (int i = 0; i < 16; i++) put_byte(8'(8'hC0 + i + from), 1);
    close_and_expect(1, $sformatf("R4 full page from %0d", from));
  endtask

  task automatic t_busy_ignore();
    enable_both();
    open_burst(2);
    put_byte(8'h42, 1);
    close_burst();
    check(commit_busy == 1, "R9 commit started", 128'(commit_busy), 1);
    open_burst(4);
    put_byte(8'hEE, 0);
    close_burst();
    check(shadow_flat == pack(exp_sh), "R9 shadow frozen", shadow_flat, pack(exp_sh));
    repeat (NCYC) @(negedge clk);
    check(commit_busy == 0, "R9 no second commit", 128'(commit_busy), 0);
    for (int i = 0; i < 16; i++) exp_nv[i] = exp_sh[i];
    check(nv_flat == pack(exp_nv), "R9 image from first burst", nv_flat, pack(exp_nv));
    open_burst(0);
    put_byte(8'h99, 0);
    close_and_expect(0, "R7 R8 write after commit discarded");
  endtask

  task automatic t_read_between();
    enable_both();
    open_burst(2);
    put_byte(8'h5A, 1);
    @(negedge clk) begin rd_en = 1; rd_addr = 4'd2; end
    @(negedge clk) rd_en = 0;
    check(rd_data == 8'h5A, "R10 read value", 128'(rd_data), 128'h5A);
    put_byte(8'hA5, 1);
    check(exp_sh[3] == 8'hA5, "R10 model", 128'(exp_sh[3]), 128'hA5);
    close_and_expect(1, "R10 burst survives read");
  endtask

  task automatic t_empty_stop();
    enable_both();
    open_burst(2);
    close_and_expect(0, "R11 empty burst");
    check(wen_stage1 && wen_stage2, "R11 enables kept",
          128'({wen_stage1, wen_stage2}), 128'b11);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin exp_sh[i] = 0; exp_nv[i] = 0; end
    mptr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_enable_order();
    t_wrap_commit();
    t_upper_ends();
    t_window_scan();
    t_full_page(1);
    t_full_page(9);
    t_busy_ignore();
    t_read_between();
    t_empty_stop();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule